// File: doc/BRIEF.md
# Network Port Reset and Configuration Sequencer

This block brings a network port out of reset and into a configured state. Three causes can start a full port reset: the supply and oscillator reported as good (`pwr_good_i`) falling low, software setting the reset bit of the control register, and leaving the software suspend mode. Entering suspend clears all sequencer state and holds the port in reset until software writes the control register again.

After any full reset the sequencer waits a fixed calibration time of `CAL_CYCLES` clocks and then sets the init-done status bit. One cycle later it samples the serial-EEPROM data-in sense pin. If the pin is high, an EEPROM is taken to be present and a configuration load is requested. The load request is held until the external loader answers with load-done. If the pin is low, a one-cycle pulse tells the register file to take its built-in default values.

A separate EEPROM reload strobe repeats only the load or defaults step. It uses the presence result already stored, without a new calibration wait and without sampling the sense pin again. Register access strobes from the host are acknowledged only when the port is ready. At all other times they return a not-ready indication.

Top module: `netport_init_seq`

## Requirements
- R1: While `pwr_good_i` is low (and under `rst_n`), the port stays in reset: `port_rst_o`=1, status bit 0 (init done)=0, status bit 1 (EEPROM busy)=1, `load_req_o`=0.
- R2: A control write with bit 6 set (and bit 1 clear) while powered and not suspended puts the port into reset in the next cycle, with init done cleared and busy set.
- R3: Control bit 6 reads back as 1 only during the reset cycle that a software reset started, and clears itself the cycle after.
- R4: Init done rises after exactly `CAL_CYCLES` cycles in which the port is out of reset with init done still low, counted from the end of the reset cycle.
- R5: A control write with bit 1 set enters suspend: control bit 1 reads 1, `port_rst_o`=1, status bits 2..0 read 0. Any later control write with bit 1 clear leaves suspend through a full reset.
- R6: The cycle after init done rises, the sense pin is sampled. High stores status bit 2 (EEPROM present)=1 and starts the load path. Low starts the defaults path.
- R7: `load_req_o` and the busy bit stay high until `load_done_i` is seen, and both are low in the following cycle.
- R8: On the defaults path, `dflt_apply_o` is high for exactly one cycle and busy is low in the cycle after.
- R9: An access strobe (`acc_rd_i` or `acc_wr_i`) gives `acc_ack_o`=1 only in the ready state. In every other state, including while busy, it gives `acc_nrdy_o`=1 and no acknowledge. Without a strobe, both outputs are 0.
- R10: `ee_reload_i` in the ready state sets busy and repeats the load or defaults step chosen by the stored presence bit. The sense pin is ignored, and init done stays 1.
- R11: Priority among causes in one cycle: power-good low over a suspend write, and a suspend write over the software reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good_i | input | 1 | Supply and oscillator good |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | REG_W | Control write data: bit 6 reset, bit 1 suspend |
| ee_sense_i | input | 1 | EEPROM data-in pin sense |
| ee_reload_i | input | 1 | EEPROM-only reload strobe |
| load_done_i | input | 1 | Configuration load finished |
| acc_rd_i | input | 1 | Host register read strobe |
| acc_wr_i | input | 1 | Host register write strobe |
| ctl_o | output | REG_W | Control readback: bit 6 reset, bit 1 suspend |
| stat_o | output | REG_W | Status: bit 0 init done, bit 1 busy, bit 2 EEPROM present |
| load_req_o | output | 1 | Configuration load request |
| dflt_apply_o | output | 1 | One-cycle default-values pulse |
| port_rst_o | output | 1 | Port held in reset |
| acc_ack_o | output | 1 | Access acknowledged |
| acc_nrdy_o | output | 1 | Access refused, port not ready |

## Verification
A wrong sequencer state shows at the ports within one cycle. `port_rst_o`, `load_req_o`, `dflt_apply_o` and the ack or not-ready pair each decode the state directly, so any mismatch appears on them at once. Bad status flags (init done, busy, present) appear on `stat_o` in the cycle after the faulty update. A miscounted calibration shows only when init done rises, so the bench measures the full calibration window from the ports.

// File: rtl/nprc_pkg.sv
package nprc_pkg;
  typedef enum logic [2:0] {
    ST_RST   = 3'd0,
    ST_CAL   = 3'd1,
    ST_SENSE = 3'd2,
    ST_LOAD  = 3'd3,
    ST_DFLT  = 3'd4,
    ST_READY = 3'd5,
    ST_SUSP  = 3'd6
  } seq_state_e;

  localparam int CTL_RST_BIT  = 6;
  localparam int CTL_SUSP_BIT = 1;
  localparam int STAT_INIT    = 0;
  localparam int STAT_BUSY    = 1;
  localparam int STAT_PRES    = 2;
endpackage

// File: rtl/nprc_rst_sync.sv
module nprc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nprc_cal_timer.sv
module nprc_cal_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = en_i || (cnt_q != '0);

  always_comb begin
    cnt_d = en_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/netport_init_seq.sv
module netport_init_seq
  import nprc_pkg::*;
#(
  parameter int CAL_CYCLES = 500000,
  parameter int REG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good_i,
  input  logic             ctl_wr_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             ee_sense_i,
  input  logic             ee_reload_i,
  input  logic             load_done_i,
  input  logic             acc_rd_i,
  input  logic             acc_wr_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] stat_o,
  output logic             load_req_o,
  output logic             dflt_apply_o,
  output logic             port_rst_o,
  output logic             acc_ack_o,
  output logic             acc_nrdy_o
);
  seq_state_e state_q, state_d;
  logic init_q, init_d;
  logic busy_q, busy_d;
  logic pres_q, pres_d;
  logic ctl_rst_q, ctl_rst_d;
  logic rst_sync_n;
  logic cal_done;
  logic sw_susp, sw_rst;
  logic acc_req, ready;

  nprc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nprc_cal_timer #(.CYCLES(CAL_CYCLES)) u_cal_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (state_q == ST_CAL),
    .done_o (cal_done)
  );

  assign sw_susp = ctl_wr_i && ctl_wdata_i[CTL_SUSP_BIT];
  assign sw_rst  = ctl_wr_i && ctl_wdata_i[CTL_RST_BIT];

  always_comb begin
    state_d   = state_q;
    init_d    = init_q;
    busy_d    = busy_q;
    pres_d    = pres_q;
    ctl_rst_d = ctl_rst_q;
    if (!pwr_good_i) begin
      state_d   = ST_RST;
      init_d    = 1'b0;
      busy_d    = 1'b1;
      pres_d    = 1'b0;
      ctl_rst_d = 1'b0;
    end else if (sw_susp) begin
      state_d   = ST_SUSP;
      init_d    = 1'b0;
      busy_d    = 1'b0;
      pres_d    = 1'b0;
      ctl_rst_d = 1'b0;
    end else if (state_q == ST_SUSP) begin
      if (ctl_wr_i) begin
        state_d = ST_RST;
        busy_d  = 1'b1;
      end
    end else if (sw_rst) begin
      state_d   = ST_RST;
      init_d    = 1'b0;
      busy_d    = 1'b1;
      pres_d    = 1'b0;
      ctl_rst_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_RST: begin
          state_d   = ST_CAL;
          ctl_rst_d = 1'b0;
        end
        ST_CAL: begin
          if (cal_done) begin
            state_d = ST_SENSE;
            init_d  = 1'b1;
          end
        end
        ST_SENSE: begin
          pres_d  = ee_sense_i;
          state_d = ee_sense_i ? ST_LOAD : ST_DFLT;
        end
        ST_LOAD: begin
          if (load_done_i) begin
            state_d = ST_READY;
            busy_d  = 1'b0;
          end
        end
        ST_DFLT: begin
          state_d = ST_READY;
          busy_d  = 1'b0;
        end
        ST_READY: begin
          if (ee_reload_i) begin
            busy_d  = 1'b1;
            state_d = pres_q ? ST_LOAD : ST_DFLT;
          end
        end
        default: state_d = ST_RST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_RST;
      init_q    <= 1'b0;
      busy_q    <= 1'b1;
      pres_q    <= 1'b0;
      ctl_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      init_q    <= init_d;
      busy_q    <= busy_d;
      pres_q    <= pres_d;
      ctl_rst_q <= ctl_rst_d;
    end
  end

  always_comb begin
    ctl_o               = '0;
    ctl_o[CTL_RST_BIT]  = ctl_rst_q;
    ctl_o[CTL_SUSP_BIT] = (state_q == ST_SUSP);
    stat_o              = '0;
    stat_o[STAT_INIT]   = init_q;
    stat_o[STAT_BUSY]   = busy_q;
    stat_o[STAT_PRES]   = pres_q;
  end

  assign port_rst_o   = (state_q == ST_RST) || (state_q == ST_SUSP);
  assign load_req_o   = (state_q == ST_LOAD);
  assign dflt_apply_o = (state_q == ST_DFLT);
  assign acc_req      = acc_rd_i || acc_wr_i;
  assign ready        = (state_q == ST_READY);
  assign acc_ack_o    = acc_req && ready;
  assign acc_nrdy_o   = acc_req && !ready;
endmodule

// File: rtl/netport_init_seq_chk.sv
module netport_init_seq_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             pwr_good_i,
  input logic             ctl_wr_i,
  input logic [REG_W-1:0] ctl_wdata_i,
  input logic             load_done_i,
  input logic             acc_rd_i,
  input logic             acc_wr_i,
  input logic [REG_W-1:0] ctl_o,
  input logic [REG_W-1:0] stat_o,
  input logic             load_req_o,
  input logic             dflt_apply_o,
  input logic             port_rst_o,
  input logic             acc_ack_o,
  input logic             acc_nrdy_o
);
  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_good_i |=> port_rst_o && !stat_o[0] && stat_o[1]); // R1

  AST_SW_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pwr_good_i && ctl_wr_i && ctl_wdata_i[6] && !ctl_wdata_i[1] && !ctl_o[1]
    |=> port_rst_o && ctl_o[6] && !stat_o[0]); // R2

  AST_RST_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_o[6] && pwr_good_i && !ctl_wr_i |=> !ctl_o[6]); // R3

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_o[1] |-> port_rst_o && (stat_o[2:0] == 3'b000)); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_req_o && !load_done_i && pwr_good_i && !ctl_wr_i |=> load_req_o); // R7

  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_req_o |-> stat_o[1]); // R7

  AST_DFLT_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dflt_apply_o && pwr_good_i && !ctl_wr_i |=> !dflt_apply_o && !stat_o[1]); // R8

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_rd_i || acc_wr_i) && stat_o[1] |-> acc_nrdy_o && !acc_ack_o); // R9

  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({acc_ack_o, acc_nrdy_o})); // R9
endmodule

bind netport_init_seq netport_init_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .pwr_good_i   (pwr_good_i),
  .ctl_wr_i     (ctl_wr_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .load_done_i  (load_done_i),
  .acc_rd_i     (acc_rd_i),
  .acc_wr_i     (acc_wr_i),
  .ctl_o        (ctl_o),
  .stat_o       (stat_o),
  .load_req_o   (load_req_o),
  .dflt_apply_o (dflt_apply_o),
  .port_rst_o   (port_rst_o),
  .acc_ack_o    (acc_ack_o),
  .acc_nrdy_o   (acc_nrdy_o)
);

// File: tb/netport_init_seq_tb_top.sv
`timescale 1ns/1ps
module netport_init_seq_tb_top;
  localparam int CAL = 20;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, wr = 1'b0, sense = 1'b0, reload = 1'b0, ldone = 1'b0, ard = 1'b0, awr = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] ctl_o, stat_o;
  logic load_req, dflt, prst, ack, nrdy;

  int checks = 0;
  int errs = 0;
  bit chk_en = 1'b0;
  int cyc = 0;

  always #10 clk = ~clk;

  netport_init_seq #(.CAL_CYCLES(CAL), .REG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .ctl_wr_i(wr), .ctl_wdata_i(wd),
    .ee_sense_i(sense), .ee_reload_i(reload), .load_done_i(ldone),
    .acc_rd_i(ard), .acc_wr_i(awr), .ctl_o(ctl_o), .stat_o(stat_o),
    .load_req_o(load_req), .dflt_apply_o(dflt), .port_rst_o(prst),
    .acc_ack_o(ack), .acc_nrdy_o(nrdy)
  );

  // Expected behaviour model; states: 0 reset, 1 cal, 2 sense, 3 load, 4 defaults, 5 ready, 6 suspend
  int m_st = 0, m_cnt = 0;
  bit m_init = 0, m_busy = 1, m_pres = 0, m_c6 = 0;

  function automatic void model_step();
    if (!pg) begin m_st = 0; m_init = 0; m_busy = 1; m_pres = 0; m_c6 = 0; end
    else if (wr && wd[1]) begin m_st = 6; m_init = 0; m_busy = 0; m_pres = 0; m_c6 = 0; end
    else if (m_st == 6) begin if (wr) begin m_st = 0; m_busy = 1; end end
    else if (wr && wd[6]) begin m_st = 0; m_init = 0; m_busy = 1; m_pres = 0; m_c6 = 1; end
    else begin
      case (m_st)
        0: begin m_st = 1; m_cnt = 0; m_c6 = 0; end
        1: begin if (m_cnt == CAL - 1) begin m_st = 2; m_init = 1; end else m_cnt++; end
        2: begin m_pres = sense; m_st = sense ? 3 : 4; end
        3: if (ldone) begin m_st = 5; m_busy = 0; end
        4: begin m_st = 5; m_busy = 0; end
        5: if (reload) begin m_busy = 1; m_st = m_pres ? 3 : 4; end
        default: m_st = 0;
      endcase
    end
  endfunction

  always @(posedge clk) if (rst_n || !pg) model_step();

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int run_len = 0;
  bit prev_init = 0;

  always @(negedge clk) begin
    #2;
    if (chk_en) begin
      chk("R1 port_rst", int'(prst), int'(m_st == 0 || m_st == 6));
      chk("R3 ctl bit6", int'(ctl_o[6]), int'(m_c6));
      chk("R5 ctl bit1", int'(ctl_o[1]), int'(m_st == 6));
      chk("R4 init", int'(stat_o[0]), int'(m_init));
      chk("R7 busy", int'(stat_o[1]), int'(m_busy));
      chk("R6 present", int'(stat_o[2]), int'(m_pres));
      chk("R7 load_req", int'(load_req), int'(m_st == 3));
      chk("R8 dflt", int'(dflt), int'(m_st == 4));
      chk("R9 ack", int'(ack), int'((ard || awr) && m_st == 5));
      chk("R9 nrdy", int'(nrdy), int'((ard || awr) && m_st != 5));
      if (prst) run_len = 0;
      else if (!stat_o[0]) run_len++;
      if (stat_o[0] && !prev_init && !prst) chk("R4 cal length", run_len, CAL);
      prev_init = stat_o[0];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  task automatic quiet();
    wr = 0; wd = '0; reload = 0; ldone = 0; ard = 0; awr = 0; pg = 1;
  endtask

  task automatic write_ctl(input logic [W-1:0] v);
    @(negedge clk); wr = 1; wd = v;
    @(negedge clk); wr = 0; wd = '0; #2;
  endtask

  task automatic wait_for_ready();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #2;
      if (!prst && !stat_o[1] && stat_o[0]) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_en = 1;
    #2;
    chk("R1 reset port_rst", int'(prst), 1);
    chk("R1 reset busy", int'(stat_o[1]), 1);
    chk("R1 reset init", int'(stat_o[0]), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    pg = 1; sense = 1;
    // power-up with EEPROM present
    for (int i = 0; i < 200 && !load_req; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    #2; chk("R7 request held", int'(load_req), 1);
    @(negedge clk); ldone = 1;
    @(negedge clk); ldone = 0; #2;
    chk("R7 request dropped", int'(load_req), 0);
    chk("R7 busy dropped", int'(stat_o[1]), 0);
    @(negedge clk); ard = 1; #2;
    chk("R9 ack when ready", int'(ack), 1);
    @(negedge clk); ard = 0;

    // R10: reload ignores sense pin, no new calibration
    sense = 0;
    @(negedge clk); reload = 1;
    @(negedge clk); reload = 0; #2;
    chk("R10 reload load_req", int'(load_req), 1);
    chk("R10 init kept", int'(stat_o[0]), 1);
    chk("R10 busy set", int'(stat_o[1]), 1);
    @(negedge clk); ldone = 1;
    @(negedge clk); ldone = 0;

    // R11: suspend beats reset bit
    write_ctl(8'h42);
    chk("R11 suspend wins", int'(ctl_o[1]), 1);
    chk("R11 no reset bit", int'(ctl_o[6]), 0);
    chk("R5 status quiet", int'(stat_o[2:0]), 0);
    write_ctl(8'h00);
    chk("R5 exit reset", int'(prst), 1);
    chk("R5 exit suspended", int'(ctl_o[1]), 0);
    wait_for_ready();
    chk("R6 absent stored", int'(stat_o[2]), 0);

    // R2 / R3 software reset
    write_ctl(8'h40);
    chk("R2 reset entered", int'(prst), 1);
    chk("R3 bit set", int'(ctl_o[6]), 1);
    @(negedge clk); #2;
    chk("R3 bit self-clear", int'(ctl_o[6]), 0);

    // R11: power-good low beats suspend write
    @(negedge clk); pg = 0; wr = 1; wd = 8'h02;
    @(negedge clk); quiet(); #2;
    chk("R11 power wins", int'(ctl_o[1]), 0);
    chk("R1 power low busy", int'(stat_o[1]), 1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      pg     = ($urandom % 300) != 0;
      wr     = ($urandom % 60) == 0;
      wd     = W'($urandom) & 8'h42;
      sense  = $urandom % 2;
      reload = ($urandom % 25) == 0;
      ldone  = ($urandom % 5) == 0;
      ard    = ($urandom % 4) == 0;
      awr    = ($urandom % 4) == 0;
    end
    @(negedge clk); quiet();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial void'($urandom(32'h1234_5678));
endmodule